// File: doc/BRIEF.md
# Double-Width Restoring Divider with Divide-Error Detection

This block divides a dividend of twice the operand width, presented as a high half and a low half, by a divisor of operand width. It returns a quotient of operand width on the low-half output and a remainder of operand width on the high-half output. Each operation picks signed or unsigned arithmetic on its own. The operand width `W` is a parameter.

An operation starts with a one-cycle `start_i` pulse while the block is idle. The block then computes one quotient bit per cycle with restoring shift-and-subtract steps, and reports completion with a one-cycle `done_o` pulse. `err_o` is valid during that pulse. A divide error means a zero divisor or a quotient that does not fit in `W` bits.

An error that the operands alone reveal is reported after a single busy cycle, with no iteration. An error found only once the quotient is known is reported at the normal latency. On any error the result outputs keep their previous values.

Top module: `dw_divider`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o`, `quot_o` and `rem_o` are all zero.
- R2: A `start_i` seen while idle is accepted at that clock edge, and `busy_o` is high from the next cycle until `done_o` pulses. `done_o` lasts exactly one cycle, and `busy_o` is low while it is high. Without an early fault, `busy_o` stays high for exactly `W+1` cycles.
- R3: `start_i` while `busy_o` is high is ignored: the running operation finishes with the operands captured at acceptance.
- R4: A zero divisor gives `err_o=1` with `done_o` after one busy cycle, and `quot_o`/`rem_o` keep their previous values.
- R5: In unsigned mode (`signed_i=0`), a high half that is nonzero and not less than the divisor (equality included) gives `err_o=1` after one busy cycle, with the outputs unchanged.
- R6: In unsigned mode with no fault, `quot_o` is the floor of `{hi,lo}/divisor` and `rem_o` is the remainder. A zero high half gives plain `lo/divisor`.
- R7: In signed mode (`signed_i=1`, both values in two's complement), the quotient truncates toward zero and the remainder is zero or carries the dividend's sign.
- R8: In signed mode, a dividend magnitude whose upper `W` bits are not below the divisor magnitude is an early fault: `err_o=1` after one busy cycle, outputs unchanged.
- R9: In signed mode with operand signs that differ, a quotient magnitude above `2^(W-1)` is an error. With equal signs, a magnitude of `2^(W-1)` or more is an error. In both cases the error appears at the normal latency and the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dvd_hi_i | input | W | Upper half of the dividend |
| dvd_lo_i | input | W | Lower half of the dividend |
| dvs_i | input | W | Divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error, valid with `done_o` |
| quot_o | output | W | Quotient (low-half result) |
| rem_o | output | W | Remainder (high-half result) |

## Verification
On every cycle the assertions check the handshake shape: done is a single pulse, done and busy are never high together, and an error appears only with done. They also check that the result outputs stay frozen on an error, that captured operands do not move while busy, and that the partial remainder stays below the divisor magnitude throughout the iteration. The arithmetic itself can only be shown by the bench's scenarios, since the assertions do not recompute any quotient. These scenarios compare against an independent model: random operands, the most negative dividend over minus one, zero divisors, a high half equal to the divisor, and the signed boundary at `2^(W-1)`. The bench also measures the busy length that separates early faults from late ones.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
// Converts operands to magnitudes and detects faults visible before iterating.
module div_operand_prep #(
    parameter int W = 16
) (
    input  logic         signed_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] mag_hi_o,
    output logic [W-1:0] mag_lo_o,
    output logic [W-1:0] mag_dvs_o,
    output logic         neg_dvd_o,
    output logic         neg_dvs_o,
    output logic         fault_o
);
    localparam int DW = 2 * W;

    logic [DW-1:0] dvd_raw;
    logic [DW-1:0] dvd_mag;
    logic          dvs_zero;

    always_comb begin
        dvd_raw   = {hi_i, lo_i};
        neg_dvd_o = signed_i & hi_i[W-1];
        neg_dvs_o = signed_i & dvs_i[W-1];
        dvd_mag   = neg_dvd_o ? (~dvd_raw + DW'(1)) : dvd_raw;
        mag_hi_o  = dvd_mag[DW-1:W];
        mag_lo_o  = dvd_mag[W-1:0];
        mag_dvs_o = neg_dvs_o ? (~dvs_i + W'(1)) : dvs_i;
        dvs_zero  = (dvs_i == '0);
        // A zero high half never trips the compare because the divisor is nonzero.
        fault_o   = dvs_zero | (mag_hi_o >= mag_dvs_o);
    end
endmodule

// File: rtl/div_restore_step.sv
// One restoring step: shift the pair left, conditionally subtract, insert quotient bit.
module div_restore_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W:0]   wide;
    logic         take;

    always_comb begin
        wide = {hi_i, lo_i[W-1]};
        take = (wide >= {1'b0, dvs_i});
        hi_o = take ? (wide[W-1:0] - dvs_i) : wide[W-1:0];
        lo_o = {lo_i[W-2:0], take};
    end
endmodule

// File: rtl/div_sign_fixup.sv
// Applies signs to magnitude results and checks the asymmetric signed limits.
module div_sign_fixup #(
    parameter int W = 16
) (
    input  logic [W-1:0] mag_q_i,
    input  logic [W-1:0] mag_r_i,
    input  logic         neg_dvd_i,
    input  logic         neg_dvs_i,
    input  logic         signed_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic diff_sign;

    always_comb begin
        diff_sign = neg_dvd_i ^ neg_dvs_i;
        if (!signed_i) begin
            ovf_o  = 1'b0;
            quot_o = mag_q_i;
        end else if (diff_sign) begin
            ovf_o  = (mag_q_i > HALF);
            quot_o = ~mag_q_i + W'(1);
        end else begin
            ovf_o  = (mag_q_i >= HALF);
            quot_o = mag_q_i;
        end
        rem_o = neg_dvd_i ? (~mag_r_i + W'(1)) : mag_r_i;
    end
endmodule

// File: rtl/dw_divider.sv
module dw_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         err_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        div_state_e   state;
        logic [CW-1:0] cnt;
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic [W-1:0] md;
        logic         sgn;
        logic         neg_dvd;
        logic         neg_dvs;
        logic         err_pend;
        logic [W-1:0] quot;
        logic [W-1:0] rem;
        logic         done;
        logic         err;
    } div_regs_t;

    div_regs_t r_d, r_q;

    logic [W-1:0] p_hi, p_lo, p_md;
    logic         p_neg_dvd, p_neg_dvs, p_fault;
    logic [W-1:0] s_hi, s_lo;
    logic [W-1:0] f_quot, f_rem;
    logic         f_ovf;

    div_operand_prep #(.W(W)) i_prep (
        .signed_i (signed_i),
        .hi_i     (dvd_hi_i),
        .lo_i     (dvd_lo_i),
        .dvs_i    (dvs_i),
        .mag_hi_o (p_hi),
        .mag_lo_o (p_lo),
        .mag_dvs_o(p_md),
        .neg_dvd_o(p_neg_dvd),
        .neg_dvs_o(p_neg_dvs),
        .fault_o  (p_fault)
    );

    div_restore_step #(.W(W)) i_step (
        .hi_i (r_q.hi),
        .lo_i (r_q.lo),
        .dvs_i(r_q.md),
        .hi_o (s_hi),
        .lo_o (s_lo)
    );

    div_sign_fixup #(.W(W)) i_fix (
        .mag_q_i  (r_q.lo),
        .mag_r_i  (r_q.hi),
        .neg_dvd_i(r_q.neg_dvd),
        .neg_dvs_i(r_q.neg_dvs),
        .signed_i (r_q.sgn),
        .quot_o   (f_quot),
        .rem_o    (f_rem),
        .ovf_o    (f_ovf)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.hi       = p_hi;
                    r_d.lo       = p_lo;
                    r_d.md       = p_md;
                    r_d.sgn      = signed_i;
                    r_d.neg_dvd  = p_neg_dvd;
                    r_d.neg_dvs  = p_neg_dvs;
                    r_d.cnt      = '0;
                    r_d.err_pend = p_fault;
                    r_d.state    = p_fault ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.hi  = s_hi;
                r_d.lo  = s_lo;
                r_d.cnt = r_q.cnt + CW'(1);
                if (r_q.cnt == LAST) begin
                    r_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                if (r_q.err_pend || f_ovf) begin
                    r_d.err = 1'b1;
                end else begin
                    r_d.quot = f_quot;
                    r_d.rem  = f_rem;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign done_o = r_q.done;
    assign err_o  = r_q.err;
    assign quot_o = r_q.quot;
    assign rem_o  = r_q.rem;

    // Handshake shape
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    assert_err_only_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
    // Results frozen when an error is reported (R4, R5, R8, R9)
    assert_err_holds_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> ($stable(quot_o) && $stable(rem_o)));
    // Captured operands do not move while busy
    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(r_q.md) && $stable(r_q.sgn) && $stable(r_q.neg_dvd)));
    // Partial remainder stays below the divisor magnitude during iteration
    assert_partial_below_divisor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) |-> (r_q.hi < r_q.md));
    assert_step_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN) |-> (r_q.cnt <= LAST));

endmodule

// File: tb/test_dw_divider.sv
module test_dw_divider;
    localparam int W = 16;
    localparam int NRAND = 300;
    localparam int NVEC = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dvd_hi_i = '0;
    logic [W-1:0] dvd_lo_i = '0;
    logic [W-1:0] dvs_i = '0;
    logic         busy_o, done_o, err_o;
    logic [W-1:0] quot_o, rem_o;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] last_q = '0;
    logic [W-1:0] last_r = '0;

    always #10 clk = ~clk;

    dw_divider #(.W(W)) i_dw_divider (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i), .dvs_i(dvs_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .quot_o(quot_o), .rem_o(rem_o)
    );

    // {signed, hi, lo, divisor, expected error}
    localparam logic [3*W+1:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 16'h0064, 16'h0007, 1'b0},
        {1'b0, 16'h0001, 16'h0000, 16'h0002, 1'b0},
        {1'b0, 16'h0005, 16'h0000, 16'h0005, 1'b1},
        {1'b0, 16'h0000, 16'h1234, 16'h0000, 1'b1},
        {1'b1, 16'hFFFF, 16'hFF9C, 16'h0007, 1'b0},
        {1'b1, 16'h8000, 16'h0000, 16'hFFFF, 1'b1},
        {1'b1, 16'hFFFF, 16'h8000, 16'hFFFF, 1'b1},
        {1'b1, 16'hFFFF, 16'h8000, 16'h0001, 1'b0},
        {1'b1, 16'h0000, 16'h8000, 16'hFFFF, 1'b0},
        {1'b1, 16'h0000, 16'h8000, 16'h0001, 1'b1},
        {1'b0, 16'hFFFE, 16'hFFFF, 16'hFFFF, 1'b0},
        {1'b1, 16'h0000, 16'h0007, 16'hFFFE, 1'b0}
    };

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Independent model; returns error, quotient, remainder and whether the fault is early.
    task automatic model(input logic sg, input logic [W-1:0] hi, input logic [W-1:0] lo,
                         input logic [W-1:0] dv, output logic e, output logic [W-1:0] q,
                         output logic [W-1:0] r, output logic early);
        longint nq, nr, ad, adv;
        e = 0; early = 0; q = '0; r = '0;
        if (dv == '0) begin
            e = 1; early = 1;
        end else if (!sg) begin
            nq = longint'({hi, lo}) / longint'(dv);
            nr = longint'({hi, lo}) % longint'(dv);
            e = (nq > 65535); early = e;
            q = nq[W-1:0]; r = nr[W-1:0];
        end else begin
            ad  = longint'($signed({hi, lo}));
            adv = longint'($signed(dv));
            nq = ad / adv;
            nr = ad % adv;
            q = nq[W-1:0]; r = nr[W-1:0];
            e = (nq > 32767) || (nq < -32768);
            if (ad < 0) ad = -ad;
            if (adv < 0) adv = -adv;
            early = (ad >= adv * 65536);
        end
    endtask

    task automatic run_op(input logic sg, input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] dv, input string req, input bit disturb);
        logic e, early;
        logic [W-1:0] q, r;
        int busy_cnt = 0;
        int guard = 0;
        model(sg, hi, lo, dv, e, q, r, early);
        @(negedge clk);
        signed_i = sg; dvd_hi_i = hi; dvd_lo_i = lo; dvs_i = dv; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && guard < 100) begin
            if (busy_o) busy_cnt++;
            if (disturb && busy_cnt == 3) begin
                // R3: new operands and a start pulse mid-run
                start_i = 1'b1; signed_i = ~sg; dvd_hi_i = '0; dvd_lo_i = 16'h00FF; dvs_i = 16'h0003;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        check(req, "done seen", (guard < 100) ? 1 : 0, 1);
        check("R2", "busy during done", busy_o, 0);
        check(req, "err", err_o, e);
        check("R2", "busy cycles", busy_cnt, early ? 1 : W + 1);
        if (!e) begin
            last_q = q; last_r = r;
        end
        check(req, "quotient", quot_o, last_q);
        check(req, "remainder", rem_o, last_r);
        @(negedge clk);
        check("R2", "done single cycle", done_o, 0);
        check("R3", "no relaunch after run", busy_o, 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", busy_o, 0);
        check("R1", "done", done_o, 0);
        check("R1", "err", err_o, 0);
        check("R1", "quot", quot_o, 0);
        check("R1", "rem", rem_o, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [3*W+1:0] v;
            logic e, early;
            logic [W-1:0] q, r;
            v = VEC[i];
            model(v[3*W+1], v[3*W:2*W+1], v[2*W:W+1], v[W:1], e, q, r, early);
            check("R9", "table err vs model", e, v[0]);
            run_op(v[3*W+1], v[3*W:2*W+1], v[2*W:W+1], v[W:1],
                   v[3*W+1] ? "R7" : "R6", 1'b0);
        end

        // Directed corner cases
        run_op(1'b0, 16'h0000, 16'h0064, 16'h0000, "R4", 1'b0);
        run_op(1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, "R4", 1'b0);
        run_op(1'b0, 16'h1234, 16'h0000, 16'h1234, "R5", 1'b0);
        run_op(1'b0, 16'h1233, 16'hFFFF, 16'h1234, "R6", 1'b0);
        run_op(1'b1, 16'h8000, 16'h0000, 16'hFFFF, "R8", 1'b0);
        run_op(1'b1, 16'hC000, 16'h0000, 16'h4000, "R8", 1'b0);
        run_op(1'b1, 16'hFFFF, 16'h8000, 16'hFFFF, "R9", 1'b0);
        run_op(1'b1, 16'h0000, 16'h8000, 16'hFFFF, "R9", 1'b0);
        run_op(1'b1, 16'hFFFF, 16'h7FFF, 16'h0001, "R9", 1'b0);
        run_op(1'b1, 16'hFFFF, 16'hFF9B, 16'h000A, "R7", 1'b0);
        run_op(1'b0, 16'h0003, 16'h1111, 16'h0100, "R3", 1'b1);
        run_op(1'b1, 16'hFFFF, 16'hFC18, 16'hFFF9, "R3", 1'b1);

        for (int i = 0; i < NRAND; i++) begin
            logic sg;
            logic [W-1:0] hi, lo, dv;
            sg = 1'($urandom);
            lo = W'($urandom);
            dv = W'($urandom);
            if (i % 3 == 0) hi = W'($urandom);
            else if (sg) hi = {W{lo[W-1]}};
            else hi = W'($urandom) % (dv | 16'h0001);
            if (i % 17 == 0) dv = '0;
            run_op(sg, hi, lo, dv, sg ? "R7" : "R6", 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule